// File: doc/BRIEF.md
# Single-Cycle Instruction Decoder and Next-PC Unit

This block is the control heart of a 16-bit processor that finishes every instruction in a single clock cycle. The instruction word arrives combinationally from an asynchronous instruction ROM that is addressed by the block's own program counter. Within the same cycle the block splits the word into register addresses and decodes the operation class into datapath controls. It also forms the immediate operand and decides where the program counter goes next. The register file, the ALU and the data memory sit outside the block. The only datapath value that comes back in is the operand read through the first source port, which the block tests for zero.

The word has four fields. Bits [15:13] give the operation class and bits [12:9] give the ALU function. Bits [8:6], [5:3] and [2:0] hold three 3-bit register fields: destination, first source and second source. Those three fields drive the register-file address lines with no decoding. An immediate instruction puts a 3-bit constant in place of the second source. A branch or jump forms a signed 6-bit displacement from the destination field (high part) and the second-source field (low part). That displacement is sign-extended and added to the program counter.

Top module: `cu_decoder`

## Requirements
- R1: While `rst_n` is low, `pc_o` is 0, and the first fetch after reset is from address 0.
- R2: For every instruction, `dr_addr_o` = instr[8:6], `sa_addr_o` = instr[5:3] and `sb_addr_o` = instr[2:0].
- R3: The class in instr[15:13] is decoded as follows: 000 register ALU op, 100 immediate ALU op, 001 load, 010 store, 110 branch-if-zero, 101 relative jump, 011 and 111 no-op. `alu_fn_o` = instr[12:9] for the two ALU classes and 0 for every other class.
- R4: `imm_sel_o` is 1 only for class 100. `imm_o` is always instr[2:0] zero-extended to 16 bits.
- R5: `rf_we_o` is 1 exactly for classes 000, 100 and 001. `load_sel_o` is 1 only for class 001.
- R6: `mem_we_o` is 1 only for class 010, and the store does not write the register file.
- R7: Class 110 is taken exactly when `sa_data_i` is 0, whatever bit is set otherwise. Class 101 is always taken. No other class is ever taken. `br_taken_o` shows the decision.
- R8: When not taken, `npc_o` = `pc_o` + 1 modulo 2^16, so 0xFFFF steps to 0x0000.
- R9: When taken, `npc_o` = `pc_o` + sign-extended {instr[8:6], instr[2:0]} modulo 2^16. This covers displacements from -32 to +31, and a displacement of 0 leaves the PC unchanged.
- R10: On every rising clock edge out of reset, `pc_o` takes the `npc_o` value from before the edge.
- R11: No-op classes 011 and 111 write neither the register file nor memory, are never taken, and step the PC by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_i | input | 16 | Instruction word read from ROM at `pc_o` |
| sa_data_i | input | 16 | Operand read through the first source register port |
| pc_o | output | 16 | Program counter / instruction ROM address |
| npc_o | output | 16 | Next program counter |
| dr_addr_o | output | 3 | Destination register address |
| sa_addr_o | output | 3 | First source register address |
| sb_addr_o | output | 3 | Second source register address |
| alu_fn_o | output | 4 | ALU function select |
| imm_sel_o | output | 1 | Select immediate in place of second source |
| imm_o | output | 16 | Zero-extended 3-bit immediate |
| rf_we_o | output | 1 | Register file write enable |
| mem_we_o | output | 1 | Data memory write enable |
| load_sel_o | output | 1 | Select memory data for register write-back |
| br_taken_o | output | 1 | Branch or jump taken this cycle |

## Verification
The bench targets the displacement extremes. At -32 a design that zero-extended the displacement would jump forward by 32. At +31 a design that split the displacement fields in the wrong order would land somewhere else. At 0 a design that still added one would not hold the PC in place. A backward jump from address 4 lands on 0xFFFF, and the next step must wrap to 0; a counter that stuck or mis-carried would show up there. A zero test with only the operand's top bit set catches a zero detector that looks at too few bits. The two no-op classes catch a decoder that falls through to a write enable.

// File: rtl/cu_pkg.sv
package cu_pkg;

   localparam int CLS_W = 3;
   localparam int FN_W  = 4;

   typedef enum logic [CLS_W-1:0] {
      CLS_ALU_R = 3'b000,
      CLS_LOAD  = 3'b001,
      CLS_STORE = 3'b010,
      CLS_NOP_A = 3'b011,
      CLS_ALU_I = 3'b100,
      CLS_JUMP  = 3'b101,
      CLS_BRZ   = 3'b110,
      CLS_NOP_B = 3'b111
   } op_class_e;

   typedef struct packed {
      logic [FN_W-1:0] alu_fn;
      logic            imm_sel;
      logic            rf_we;
      logic            mem_we;
      logic            load_sel;
      logic            is_brz;
      logic            is_jmp;
   } ctrl_t;

endpackage

// File: rtl/cu_fields.sv
module cu_fields
   import cu_pkg::*;
#(
   parameter int INSTR_W    = 16,
   parameter int REG_AW     = 3,
   parameter int DATA_W     = 16,
   parameter bit IMM_SIGNED = 1'b0
) (
   input  logic [INSTR_W-1:0] instr,
   output logic [REG_AW-1:0]  dr,
   output logic [REG_AW-1:0]  sa,
   output logic [REG_AW-1:0]  sb,
   output op_class_e          cls,
   output logic [FN_W-1:0]    fn,
   output logic [DATA_W-1:0]  imm,
   output logic [DATA_W-1:0]  off
);

   localparam int OFF_W = 2 * REG_AW;

   logic [OFF_W-1:0] off_raw;

   // register fields are pure wiring
   assign sb  = instr[REG_AW-1:0];
   assign sa  = instr[2*REG_AW-1:REG_AW];
   assign dr  = instr[3*REG_AW-1:2*REG_AW];
   assign fn  = instr[INSTR_W-CLS_W-1 -: FN_W];
   assign cls = op_class_e'(instr[INSTR_W-1 -: CLS_W]);

   // displacement: destination field is the high half
   assign off_raw = {dr, sb};
   assign off     = {{(DATA_W-OFF_W){off_raw[OFF_W-1]}}, off_raw};

   generate
      if (IMM_SIGNED) begin : g_imm_sext
         assign imm = {{(DATA_W-REG_AW){sb[REG_AW-1]}}, sb};
      end else begin : g_imm_zext
         assign imm = {{(DATA_W-REG_AW){1'b0}}, sb};
      end
   endgenerate

endmodule

// File: rtl/cu_ctrl.sv
module cu_ctrl
   import cu_pkg::*;
(
   input  op_class_e       cls,
   input  logic [FN_W-1:0] fn,
   output ctrl_t           ctrl
);

   always_comb begin
      ctrl = '0;
      unique case (cls)
         CLS_ALU_R: begin
            ctrl.alu_fn = fn;
            ctrl.rf_we  = 1'b1;
         end
         CLS_ALU_I: begin
            ctrl.alu_fn  = fn;
            ctrl.imm_sel = 1'b1;
            ctrl.rf_we   = 1'b1;
         end
         CLS_LOAD: begin
            ctrl.rf_we    = 1'b1;
            ctrl.load_sel = 1'b1;
         end
         CLS_STORE: ctrl.mem_we = 1'b1;
         CLS_BRZ:   ctrl.is_brz = 1'b1;
         CLS_JUMP:  ctrl.is_jmp = 1'b1;
         CLS_NOP_A,
         CLS_NOP_B: ctrl = '0;
         default:   ctrl = '0;
      endcase
   end

endmodule

// File: rtl/cu_npc.sv
module cu_npc #(
   parameter int PC_W   = 16,
   parameter int DATA_W = 16
) (
   input  logic [PC_W-1:0]   pc,
   input  logic [DATA_W-1:0] off,
   input  logic [DATA_W-1:0] sa_data,
   input  logic              is_brz,
   input  logic              is_jmp,
   output logic              taken,
   output logic [PC_W-1:0]   npc
);

   localparam logic [PC_W-1:0] STEP = PC_W'(1);

   logic             sa_zero;
   logic [PC_W-1:0]  addend;

   assign sa_zero = (sa_data == '0);
   assign taken   = is_jmp | (is_brz & sa_zero);
   assign addend  = taken ? off[PC_W-1:0] : STEP;
   assign npc     = pc + addend;

endmodule

// File: rtl/cu_decoder.sv
module cu_decoder
   import cu_pkg::*;
#(
   parameter int              INSTR_W    = 16,
   parameter int              REG_AW     = 3,
   parameter int              DATA_W     = 16,
   parameter int              PC_W       = 16,
   parameter bit              IMM_SIGNED = 1'b0,
   parameter logic [PC_W-1:0] RESET_PC   = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [INSTR_W-1:0] instr_i,
   input  logic [DATA_W-1:0]  sa_data_i,
   output logic [PC_W-1:0]    pc_o,
   output logic [PC_W-1:0]    npc_o,
   output logic [REG_AW-1:0]  dr_addr_o,
   output logic [REG_AW-1:0]  sa_addr_o,
   output logic [REG_AW-1:0]  sb_addr_o,
   output logic [FN_W-1:0]    alu_fn_o,
   output logic               imm_sel_o,
   output logic [DATA_W-1:0]  imm_o,
   output logic               rf_we_o,
   output logic               mem_we_o,
   output logic               load_sel_o,
   output logic               br_taken_o
);

   generate
      if (INSTR_W != CLS_W + FN_W + 3 * REG_AW) begin : g_bad_layout
         $error("instruction width does not match field layout");
      end
      if (PC_W > DATA_W) begin : g_bad_pc
         $error("PC wider than the extended displacement");
      end
      if (DATA_W < 2 * REG_AW) begin : g_bad_data
         $error("data width below displacement width");
      end
   endgenerate

   op_class_e         cls;
   logic [FN_W-1:0]   fn;
   logic [DATA_W-1:0] off;
   ctrl_t             ctrl;
   logic [PC_W-1:0]   pc_q;

   cu_fields #(
      .INSTR_W    (INSTR_W),
      .REG_AW     (REG_AW),
      .DATA_W     (DATA_W),
      .IMM_SIGNED (IMM_SIGNED)
   ) u_fields (
      .instr (instr_i),
      .dr    (dr_addr_o),
      .sa    (sa_addr_o),
      .sb    (sb_addr_o),
      .cls   (cls),
      .fn    (fn),
      .imm   (imm_o),
      .off   (off)
   );

   cu_ctrl u_ctrl (
      .cls  (cls),
      .fn   (fn),
      .ctrl (ctrl)
   );

   cu_npc #(
      .PC_W   (PC_W),
      .DATA_W (DATA_W)
   ) u_npc (
      .pc      (pc_q),
      .off     (off),
      .sa_data (sa_data_i),
      .is_brz  (ctrl.is_brz),
      .is_jmp  (ctrl.is_jmp),
      .taken   (br_taken_o),
      .npc     (npc_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pc_q <= RESET_PC;
      else        pc_q <= npc_o;
   end

   assign pc_o       = pc_q;
   assign alu_fn_o   = ctrl.alu_fn;
   assign imm_sel_o  = ctrl.imm_sel;
   assign rf_we_o    = ctrl.rf_we;
   assign mem_we_o   = ctrl.mem_we;
   assign load_sel_o = ctrl.load_sel;

endmodule

// File: rtl/cu_decoder_chk.sv
module cu_decoder_chk #(
   parameter int INSTR_W = 16,
   parameter int DATA_W  = 16,
   parameter int PC_W    = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic [INSTR_W-1:0] instr_i,
   input logic [DATA_W-1:0]  sa_data_i,
   input logic [PC_W-1:0]    pc_o,
   input logic [PC_W-1:0]    npc_o,
   input logic               rf_we_o,
   input logic               mem_we_o,
   input logic               load_sel_o,
   input logic               imm_sel_o,
   input logic               br_taken_o
);

   logic [2:0] cls;
   assign cls = instr_i[INSTR_W-1 -: 3];

   AST_PC_FOLLOWS_NPC: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> pc_o == $past(npc_o)); // R10

   AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      !br_taken_o |-> npc_o == PC_W'(pc_o + 1'b1)); // R8

   AST_MEM_WRITE_STORE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |-> (cls == 3'b010) && !rf_we_o); // R6

   AST_BRZ_NONZERO_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
      (cls == 3'b110 && sa_data_i != '0) |-> !br_taken_o); // R7

   AST_NOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (cls == 3'b011 || cls == 3'b111) |-> !(rf_we_o || mem_we_o || br_taken_o)); // R11

   AST_IMM_SEL_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
      imm_sel_o |-> cls == 3'b100); // R4

   AST_LOAD_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
      load_sel_o |-> rf_we_o && cls == 3'b001); // R5

endmodule

bind cu_decoder cu_decoder_chk #(
   .INSTR_W (INSTR_W),
   .DATA_W  (DATA_W),
   .PC_W    (PC_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .instr_i    (instr_i),
   .sa_data_i  (sa_data_i),
   .pc_o       (pc_o),
   .npc_o      (npc_o),
   .rf_we_o    (rf_we_o),
   .mem_we_o   (mem_we_o),
   .load_sel_o (load_sel_o),
   .imm_sel_o  (imm_sel_o),
   .br_taken_o (br_taken_o)
);

// File: tb/tb_cu_decoder.sv
module tb_cu_decoder;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] instr_i = '0;
   logic [15:0] sa_data_i = '0;
   logic [15:0] pc_o, npc_o, imm_o;
   logic [2:0]  dr_addr_o, sa_addr_o, sb_addr_o;
   logic [3:0]  alu_fn_o;
   logic        imm_sel_o, rf_we_o, mem_we_o, load_sel_o, br_taken_o;

   int n_chk = 0;
   int n_fail = 0;
   int exp_pc = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;  // 125 MHz

   cu_decoder dut (
      .clk (clk), .rst_n (rst_n), .instr_i (instr_i), .sa_data_i (sa_data_i),
      .pc_o (pc_o), .npc_o (npc_o), .dr_addr_o (dr_addr_o),
      .sa_addr_o (sa_addr_o), .sb_addr_o (sb_addr_o), .alu_fn_o (alu_fn_o),
      .imm_sel_o (imm_sel_o), .imm_o (imm_o), .rf_we_o (rf_we_o),
      .mem_we_o (mem_we_o), .load_sel_o (load_sel_o), .br_taken_o (br_taken_o)
   );

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] mk(int c, int f, int d, int a, int b);
      return {c[2:0], f[3:0], d[2:0], a[2:0], b[2:0]};
   endfunction

   // one cycle: drive, compare with the model, advance model PC
   task automatic step(logic [15:0] ins, logic [15:0] sad);
      int c, disp, e_npc;
      bit alu, tk, nop;
      instr_i   = ins;
      sa_data_i = sad;
      #1;
      c    = int'(ins[15:13]);
      alu  = (c == 0 || c == 4);
      nop  = (c == 3 || c == 7);
      tk   = (c == 5) || (c == 6 && sad == 16'h0);
      disp = int'({ins[8:6], ins[2:0]});
      if (disp >= 32) disp -= 64;
      e_npc = tk ? (((exp_pc + disp) % 65536) + 65536) % 65536 : (exp_pc + 1) % 65536;

      chk("R10", "pc_o", 32'(pc_o), 32'(exp_pc));
      chk("R2", "dr_addr_o", 32'(dr_addr_o), 32'(ins[8:6]));
      chk("R2", "sa_addr_o", 32'(sa_addr_o), 32'(ins[5:3]));
      chk("R2", "sb_addr_o", 32'(sb_addr_o), 32'(ins[2:0]));
      chk("R3", "alu_fn_o", 32'(alu_fn_o), alu ? 32'(ins[12:9]) : 32'h0);
      chk("R4", "imm_sel_o", 32'(imm_sel_o), 32'(c == 4));
      chk("R4", "imm_o", 32'(imm_o), 32'(ins[2:0]));
      chk("R5", "rf_we_o", 32'(rf_we_o), 32'(c == 0 || c == 4 || c == 1));
      chk("R5", "load_sel_o", 32'(load_sel_o), 32'(c == 1));
      chk("R6", "mem_we_o", 32'(mem_we_o), 32'(c == 2));
      chk("R7", "br_taken_o", 32'(br_taken_o), 32'(tk));
      if (tk) chk("R9", "npc_o taken", 32'(npc_o), 32'(e_npc));
      else    chk("R8", "npc_o step", 32'(npc_o), 32'(e_npc));
      if (nop) chk("R11", "no-op quiet", 32'({rf_we_o, mem_we_o, br_taken_o}), 32'h0);
      exp_pc = e_npc;
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", "pc_o in reset", 32'(pc_o), 32'h0);
      rst_n = 1'b1;
      exp_pc = 0;
      step(mk(0, 5, 1, 2, 3), 16'h0007);   // reg ALU
      step(mk(4, 9, 6, 1, 7), 16'h0000);   // immediate ALU, imm 7
      step(mk(1, 3, 2, 4, 5), 16'h1234);   // load
      step(mk(2, 7, 3, 3, 1), 16'h0000);   // store
      step(mk(6, 0, 3, 0, 7), 16'h0000);   // R9 +31 taken -> 35
      step(mk(6, 0, 3, 0, 7), 16'h8000);   // R7 top bit only, not taken
      step(mk(6, 0, 4, 5, 0), 16'h0000);   // R9 -32 taken -> 4
      step(mk(6, 0, 0, 2, 0), 16'h0000);   // R9 zero displacement holds
      step(mk(5, 0, 7, 1, 3), 16'h00FF);   // R9 jump -5 -> 0xFFFF
      step(mk(3, 15, 7, 7, 7), 16'h0000);  // R11 no-op, R8 wrap to 0
      step(mk(7, 15, 0, 0, 0), 16'h0000);  // R11 no-op with zero operand
      step(mk(5, 0, 0, 3, 1), 16'h0001);   // R7 jump regardless of operand
      for (int i = 0; i < 400; i++) begin
         logic [15:0] r;
         r = 16'($urandom);
         step(r, ($urandom % 2 == 0) ? 16'h0 : 16'(1 << ($urandom % 16)));
      end
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule